// File: doc/BRIEF.md
# PCI parity generator and checker

This block handles even parity on the lower and upper lanes of a PCI agent that can act as bus master or as target. From the multiplexed address/data lines, the byte-enable lines and the bus phase controls, it works out which phases this agent sources and which it receives. For each phase it sources, it drives the parity bit one clock later. For each phase it receives, it compares the parity bit arriving one clock later against the value it computed from the lines it sampled.

A mismatch on a received data phase produces a one-clock data-error drive two clocks after that data phase. A mismatch on a received address phase produces a one-clock system-error drive at the same distance. Each of these drives is gated by its own enable input. A status pulse marks every detected mismatch, whatever the enables are. A second pulse marks each system-error report. The upper 64-bit lane follows the same rules. Its address phases count only when the wide request is asserted, and its data phases count only when the wide acknowledge is asserted.

The open-drain error lines are modelled as active-high drive enables. Address decoding, the data path and configuration storage are left outside the block.

Top module: `pci_parity_unit`

## Requirements
- R1: The driven lower parity bit equals the XOR of the 32 AD bits and 4 byte enables sampled in the previous cycle, so that the 37 bits together hold an even count of ones.
- R2: As master (`is_master`=1), the block drives lower parity in the cycle after an address phase (first cycle with FRAME# low after a cycle with FRAME# high). It also drives lower parity in the cycle after every write data cycle that has IRDY# low, wait states included. In any other cycle its lower output enable is low.
- R3: As target, the block never drives parity after an address phase. It drives lower parity only in the cycle after a read data cycle that has TRDY# and DEVSEL# low.
- R4: Upper parity is the XOR of the upper 32 AD bits and upper 4 byte enables. It is driven after an address phase with the wide request low (master), and after data phases with the wide acknowledge low (master write with a wide request, or target read). The upper output enable is never high while the lower one is low.
- R5: A lower data-parity mismatch on a received data transfer (IRDY# and TRDY# both low) in cycle T, checked against the parity input in T+1, raises `dperr_drv` in cycle T+2 for exactly one cycle per erroneous phase. Received transfers are master reads and target writes with DEVSEL# low. Phases this agent sources are never checked.
- R6: `dperr_drv` stays low when `perr_resp_en` is 0 or when the transfer carries the special-cycle command.
- R7: As target, an address-parity mismatch in cycle T raises `sys_err_drv` and `stat_sig` in T+2 when `serr_en` is 1. Nothing is raised when `serr_en` is 0 or when the agent is master.
- R8: `stat_det` pulses in T+2 for any detected mismatch, address or data, lower or upper, regardless of `perr_resp_en`, `serr_en` or the special-cycle command.
- R9: An upper-lane address mismatch is detected only when the wide request was low in the address phase. An upper-lane data mismatch is detected only when the wide acknowledge was low in the data phase.
- R10: While `rst_n` is low, all output enables, error drives and status pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_lo | input | 32 | Lower address/data lines |
| cbe_lo | input | 4 | Lower command/byte-enable lines |
| ad_hi | input | 32 | Upper address/data lines |
| cbe_hi | input | 4 | Upper byte-enable lines |
| frame_n | input | 1 | Transaction frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| wide_req_n | input | 1 | 64-bit transfer request, active low |
| wide_ack_n | input | 1 | 64-bit transfer acknowledge, active low |
| is_master | input | 1 | 1 when this agent owns the current transaction |
| cmd_write | input | 1 | Decoded command is a write |
| cmd_special | input | 1 | Decoded command is a special cycle |
| perr_resp_en | input | 1 | Data-error reporting enable |
| serr_en | input | 1 | System-error reporting enable |
| par_lo_i | input | 1 | Received lower parity bit |
| par_hi_i | input | 1 | Received upper parity bit |
| par_lo_o | output | 1 | Driven lower parity bit |
| par_lo_oe | output | 1 | Lower parity output enable |
| par_hi_o | output | 1 | Driven upper parity bit |
| par_hi_oe | output | 1 | Upper parity output enable |
| dperr_drv | output | 1 | Pull data-error line low |
| sys_err_drv | output | 1 | Pull system-error line low |
| stat_det | output | 1 | Pulse: parity mismatch detected |
| stat_sig | output | 1 | Pulse: system error signalled |

## Verification
The bench sweeps random address and data words through master writes, target reads and a grid of error cases. The cases cover each role, direction, enable setting, special command and wide request/acknowledge combination. It checks the one-clock offset of parity driving, including across a write wait state. A design off by a cycle there would present stale parity or drop the enable early. It checks the exact two-clock error delay and one-clock width over a two-phase burst with both phases bad. A wrong pipeline depth would merge the pulses or shift them. It checks that sourced phases and unacknowledged upper lanes are never checked. A design that checks them would raise spurious errors on its own traffic.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  localparam int PAR_MAXW = 128;
  typedef logic [PAR_MAXW-1:0] par_vec_t;

  // Bit that makes the total number of ones even.
  function automatic logic even_fill(input par_vec_t v);
    return ^v;
  endfunction
endpackage

// File: rtl/pci_par_phase.sv
module pci_par_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic trdy_n,
  input  logic wide_req_n,
  output logic addr_ph,
  output logic busy,
  output logic wide_lat
);
  logic frame_act_q;
  logic last_done;
  logic bus_idle;

  assign addr_ph   = !frame_n && !frame_act_q;
  assign last_done = busy && frame_n && !irdy_n && !trdy_n;
  assign bus_idle  = busy && frame_n && irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_act_q <= 1'b0;
      busy        <= 1'b0;
      wide_lat    <= 1'b0;
    end else begin
      frame_act_q <= !frame_n;
      if (addr_ph) begin
        busy     <= 1'b1;
        wide_lat <= !wide_req_n;
      end else if (last_done || bus_idle) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pci_par_lane.sv
module pci_par_lane #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vec,
  input  logic         drive,
  input  logic         chk_addr,
  input  logic         chk_data,
  input  logic         par_rx,
  output logic         par_tx,
  output logic         par_oe,
  output logic         addr_err,
  output logic         data_err
);
  import pci_par_pkg::*;

  par_vec_t v_ext;
  logic     par_q;
  logic     addr_q;
  logic     data_q;
  logic     mism;

  assign v_ext = par_vec_t'(vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q  <= 1'b0;
      par_oe <= 1'b0;
      addr_q <= 1'b0;
      data_q <= 1'b0;
    end else begin
      par_q  <= even_fill(v_ext);
      par_oe <= drive;
      addr_q <= chk_addr;
      data_q <= chk_data;
    end
  end

  assign par_tx   = par_q;
  assign mism     = par_rx ^ par_q;
  assign addr_err = addr_q && mism;
  assign data_err = data_q && mism;
endmodule

// File: rtl/pci_par_err.sv
module pci_par_err (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_err,
  input  logic data_err,
  input  logic spec_q,
  input  logic perr_resp_en,
  input  logic serr_en,
  output logic dperr_drv,
  output logic sys_err_drv,
  output logic stat_det,
  output logic stat_sig
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dperr_drv   <= 1'b0;
      sys_err_drv <= 1'b0;
      stat_det    <= 1'b0;
      stat_sig    <= 1'b0;
    end else begin
      dperr_drv   <= data_err && perr_resp_en && !spec_q;
      sys_err_drv <= addr_err && serr_en;
      stat_sig    <= addr_err && serr_en;
      stat_det    <= addr_err || data_err;
    end
  end
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int AD_W      = 32,
  parameter int BE_W      = 4,
  parameter bit HAS_UPPER = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_lo,
  input  logic [BE_W-1:0] cbe_lo,
  input  logic [AD_W-1:0] ad_hi,
  input  logic [BE_W-1:0] cbe_hi,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic            devsel_n,
  input  logic            wide_req_n,
  input  logic            wide_ack_n,
  input  logic            is_master,
  input  logic            cmd_write,
  input  logic            cmd_special,
  input  logic            perr_resp_en,
  input  logic            serr_en,
  input  logic            par_lo_i,
  input  logic            par_hi_i,
  output logic            par_lo_o,
  output logic            par_lo_oe,
  output logic            par_hi_o,
  output logic            par_hi_oe,
  output logic            dperr_drv,
  output logic            sys_err_drv,
  output logic            stat_det,
  output logic            stat_sig
);
  localparam int LANE_W = AD_W + BE_W;
  localparam int NL     = HAS_UPPER ? 2 : 1;

  logic addr_ph, busy, wide_lat, xfer, spec_q;
  logic lo_drv, lo_chka, lo_chkd;
  logic [NL-1:0] ln_drv, ln_chka, ln_chkd, ln_rx, ln_tx, ln_oe, ln_aerr, ln_derr;
  logic [NL-1:0][LANE_W-1:0] ln_vec;
  logic addr_err_any, data_err_any;

  pci_par_phase u_phase (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .wide_req_n(wide_req_n),
    .addr_ph(addr_ph), .busy(busy), .wide_lat(wide_lat)
  );

  assign xfer   = busy && !irdy_n && !trdy_n;
  assign lo_drv = is_master ? (addr_ph || (busy && cmd_write && !irdy_n))
                            : (!addr_ph && busy && !cmd_write && !trdy_n && !devsel_n);
  assign lo_chka = addr_ph && !is_master;
  assign lo_chkd = xfer && (is_master ? !cmd_write : (cmd_write && !devsel_n));

  assign ln_vec[0]  = {ad_lo, cbe_lo};
  assign ln_drv[0]  = lo_drv;
  assign ln_chka[0] = lo_chka;
  assign ln_chkd[0] = lo_chkd;
  assign ln_rx[0]   = par_lo_i;
  assign par_lo_o   = ln_tx[0];
  assign par_lo_oe  = ln_oe[0];

  generate
    if (HAS_UPPER) begin : g_upper
      assign ln_vec[1]  = {ad_hi, cbe_hi};
      assign ln_drv[1]  = is_master
        ? ((addr_ph && !wide_req_n) || (busy && cmd_write && !irdy_n && wide_lat && !wide_ack_n))
        : (!addr_ph && busy && !cmd_write && !trdy_n && !devsel_n && !wide_ack_n);
      assign ln_chka[1] = lo_chka && !wide_req_n;
      assign ln_chkd[1] = lo_chkd && !wide_ack_n;
      assign ln_rx[1]   = par_hi_i;
      assign par_hi_o   = ln_tx[1];
      assign par_hi_oe  = ln_oe[1];
    end else begin : g_no_upper
      assign par_hi_o  = 1'b0;
      assign par_hi_oe = 1'b0;
    end

    for (genvar g = 0; g < NL; g++) begin : g_lane
      pci_par_lane #(.W(LANE_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .vec(ln_vec[g]), .drive(ln_drv[g]),
        .chk_addr(ln_chka[g]), .chk_data(ln_chkd[g]), .par_rx(ln_rx[g]),
        .par_tx(ln_tx[g]), .par_oe(ln_oe[g]),
        .addr_err(ln_aerr[g]), .data_err(ln_derr[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spec_q <= 1'b0;
    else        spec_q <= cmd_special;
  end

  assign addr_err_any = |ln_aerr;
  assign data_err_any = |ln_derr;

  pci_par_err u_err (
    .clk(clk), .rst_n(rst_n), .addr_err(addr_err_any), .data_err(data_err_any),
    .spec_q(spec_q), .perr_resp_en(perr_resp_en), .serr_en(serr_en),
    .dperr_drv(dperr_drv), .sys_err_drv(sys_err_drv),
    .stat_det(stat_det), .stat_sig(stat_sig)
  );
endmodule

// File: rtl/pci_parity_chk.sv
module pci_parity_chk (
  input logic clk,
  input logic rst_n,
  input logic is_master,
  input logic perr_resp_en,
  input logic serr_en,
  input logic addr_ph,
  input logic par_lo_oe,
  input logic par_hi_oe,
  input logic dperr_drv,
  input logic sys_err_drv,
  input logic stat_det
);
  a_r2_master_addr_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ph && is_master) |=> par_lo_oe);

  a_r3_target_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ph && !is_master) |=> !par_lo_oe);

  a_r4_upper_within_lower: assert property (@(posedge clk) disable iff (!rst_n)
    par_hi_oe |-> par_lo_oe);

  a_r6_perr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_resp_en |=> !dperr_drv);

  a_r7_serr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_en |=> !sys_err_drv);

  a_r8_report_marks_det: assert property (@(posedge clk) disable iff (!rst_n)
    (dperr_drv || sys_err_drv) |-> stat_det);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_quiet: assert (!par_lo_oe && !par_hi_oe && !dperr_drv && !sys_err_drv && !stat_det);
    end
  end
endmodule

bind pci_parity_unit pci_parity_chk u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .perr_resp_en(perr_resp_en),
  .serr_en(serr_en), .addr_ph(addr_ph), .par_lo_oe(par_lo_oe), .par_hi_oe(par_hi_oe),
  .dperr_drv(dperr_drv), .sys_err_drv(sys_err_drv), .stat_det(stat_det)
);

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] ad_lo, ad_hi;
  logic [3:0]  cbe_lo, cbe_hi;
  logic frame_n, irdy_n, trdy_n, devsel_n, wide_req_n, wide_ack_n;
  logic is_master, cmd_write, cmd_special, perr_resp_en, serr_en;
  logic par_lo_i, par_hi_i;
  logic par_lo_o, par_lo_oe, par_hi_o, par_hi_oe;
  logic dperr_drv, sys_err_drv, stat_det, stat_sig;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_parity_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ad_lo(ad_lo), .cbe_lo(cbe_lo), .ad_hi(ad_hi),
    .cbe_hi(cbe_hi), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .wide_req_n(wide_req_n), .wide_ack_n(wide_ack_n),
    .is_master(is_master), .cmd_write(cmd_write), .cmd_special(cmd_special),
    .perr_resp_en(perr_resp_en), .serr_en(serr_en), .par_lo_i(par_lo_i),
    .par_hi_i(par_hi_i), .par_lo_o(par_lo_o), .par_lo_oe(par_lo_oe),
    .par_hi_o(par_hi_o), .par_hi_oe(par_hi_oe), .dperr_drv(dperr_drv),
    .sys_err_drv(sys_err_drv), .stat_det(stat_det), .stat_sig(stat_sig)
  );

  // Parity bit computed by counting ones.
  function automatic logic epar(input logic [31:0] a, input logic [3:0] c);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(a[i]);
    for (int i = 0; i < 4; i++)  n += int'(c[i]);
    return (n % 2) == 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_idle();
    frame_n = 1; irdy_n = 1; trdy_n = 1; devsel_n = 1; wide_req_n = 1; wide_ack_n = 1;
  endtask

  task automatic master_write(input bit wide, input bit waitst);
    logic [31:0] al, ah, dl, dh;
    logic [3:0]  cl, ch, xl, xh;
    al = $urandom; ah = $urandom; dl = $urandom; dh = $urandom;
    cl = 4'($urandom); ch = 4'($urandom); xl = 4'($urandom); xh = 4'($urandom);
    is_master = 1; cmd_write = 1; cmd_special = 0;
    frame_n = 0; wide_req_n = ~wide; ad_lo = al; cbe_lo = cl; ad_hi = ah; cbe_hi = ch;
    tick();
    check("R2 addr oe", par_lo_oe, 1);
    check("R1 addr par", par_lo_o, epar(al, cl));
    check("R4 addr hi oe", par_hi_oe, wide);
    if (wide) check("R4 addr hi par", par_hi_o, epar(ah, ch));
    frame_n = 1; wide_req_n = 1; irdy_n = 0; devsel_n = 0; wide_ack_n = ~wide;
    trdy_n = waitst; ad_lo = dl; cbe_lo = xl; ad_hi = dh; cbe_hi = xh;
    tick();
    check("R2 data oe", par_lo_oe, 1);
    check("R1 data par", par_lo_o, epar(dl, xl));
    check("R4 data hi oe", par_hi_oe, wide);
    if (wide) check("R4 data hi par", par_hi_o, epar(dh, xh));
    if (waitst) begin
      trdy_n = 0;
      tick();
      check("R2 wait oe", par_lo_oe, 1);
      check("R1 wait par", par_lo_o, epar(dl, xl));
    end
    bus_idle();
    tick();
    check("R2 release", par_lo_oe, 0);
    check("R4 release", par_hi_oe, 0);
  endtask

  task automatic target_read(input bit wide);
    logic [31:0] al, ah, dl, dh;
    logic [3:0]  cl, ch, xl, xh;
    al = $urandom; ah = $urandom; dl = $urandom; dh = $urandom;
    cl = 4'($urandom); ch = 4'($urandom); xl = 4'($urandom); xh = 4'($urandom);
    is_master = 0; cmd_write = 0; cmd_special = 0;
    frame_n = 0; wide_req_n = ~wide; ad_lo = al; cbe_lo = cl; ad_hi = ah; cbe_hi = ch;
    tick();
    check("R3 no addr drive", par_lo_oe, 0);
    check("R3 no addr hi drive", par_hi_oe, 0);
    frame_n = 1; wide_req_n = 1; irdy_n = 0; trdy_n = 0; devsel_n = 0; wide_ack_n = ~wide;
    par_lo_i = epar(al, cl); par_hi_i = epar(ah, ch);
    ad_lo = dl; cbe_lo = xl; ad_hi = dh; cbe_hi = xh;
    tick();
    check("R3 read oe", par_lo_oe, 1);
    check("R1 read par", par_lo_o, epar(dl, xl));
    check("R4 read hi oe", par_hi_oe, wide);
    if (wide) check("R4 read hi par", par_hi_o, epar(dh, xh));
    check("R7 clean addr", sys_err_drv, 0);
    bus_idle();
    tick();
    check("R3 release", par_lo_oe, 0);
    check("R5 no perr", dperr_drv, 0);
  endtask

  task automatic run_err(input string tag, input bit mst, input bit wr, input bit sp,
                         input bit wreq, input bit wack, input bit ba_lo, input bit ba_hi,
                         input bit bd_lo, input bit bd_hi, input bit e_serr,
                         input bit e_deta, input bit e_perr, input bit e_detd);
    logic [31:0] al, ah, dl, dh;
    logic [3:0]  cl, ch, xl, xh;
    al = $urandom; ah = $urandom; dl = $urandom; dh = $urandom;
    cl = 4'($urandom); ch = 4'($urandom); xl = 4'($urandom); xh = 4'($urandom);
    is_master = mst; cmd_write = wr; cmd_special = sp;
    frame_n = 0; wide_req_n = ~wreq; ad_lo = al; cbe_lo = cl; ad_hi = ah; cbe_hi = ch;
    tick();
    frame_n = 1; wide_req_n = 1; irdy_n = 0; trdy_n = 0; devsel_n = 0; wide_ack_n = ~wack;
    par_lo_i = epar(al, cl) ^ ba_lo; par_hi_i = epar(ah, ch) ^ ba_hi;
    ad_lo = dl; cbe_lo = xl; ad_hi = dh; cbe_hi = xh;
    tick();
    check({tag, " serr"}, sys_err_drv, e_serr);
    check({tag, " sig"}, stat_sig, e_serr);
    check({tag, " det addr"}, stat_det, e_deta);
    bus_idle();
    par_lo_i = epar(dl, xl) ^ bd_lo; par_hi_i = epar(dh, xh) ^ bd_hi;
    tick();
    check({tag, " perr"}, dperr_drv, e_perr);
    check({tag, " det data"}, stat_det, e_detd);
    check({tag, " serr one clk"}, sys_err_drv, 0);
    tick();
    check({tag, " perr one clk"}, dperr_drv, 0);
    cmd_special = 0;
  endtask

  task automatic burst_err();
    logic [31:0] al, d1, d2;
    logic [3:0]  cl, c1, c2;
    al = $urandom; d1 = $urandom; d2 = $urandom;
    cl = 4'($urandom); c1 = 4'($urandom); c2 = 4'($urandom);
    is_master = 0; cmd_write = 1; cmd_special = 0;
    frame_n = 0; ad_lo = al; cbe_lo = cl;
    tick();
    irdy_n = 0; trdy_n = 0; devsel_n = 0; par_lo_i = epar(al, cl); ad_lo = d1; cbe_lo = c1;
    tick();
    frame_n = 1; par_lo_i = ~epar(d1, c1); ad_lo = d2; cbe_lo = c2;
    tick();
    check("R5 burst first", dperr_drv, 1);
    bus_idle();
    par_lo_i = ~epar(d2, c2);
    tick();
    check("R5 burst second", dperr_drv, 1);
    tick();
    check("R5 burst end", dperr_drv, 0);
  endtask

  initial begin
    rst_n = 0; bus_idle();
    ad_lo = 0; ad_hi = 0; cbe_lo = 0; cbe_hi = 0;
    is_master = 0; cmd_write = 0; cmd_special = 0;
    perr_resp_en = 1; serr_en = 1; par_lo_i = 0; par_hi_i = 0;
    repeat (3) tick();
    check("R10 oe", {par_lo_oe, par_hi_oe}, 0);
    check("R10 errs", {dperr_drv, sys_err_drv, stat_det, stat_sig}, 0);
    rst_n = 1;
    tick();

    for (int i = 0; i < 24; i++) master_write(i[0], i[1]);
    for (int i = 0; i < 16; i++) target_read(i[0]);

    for (int i = 0; i < 8; i++) begin
      perr_resp_en = 1; serr_en = 1;
      run_err("R5 target write", 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 1);
      run_err("R5 master read", 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 1);
      run_err("R5 own write unchecked", 1, 1, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
      run_err("R6 special", 0, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
      run_err("R7 addr", 0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 1, 0, 0);
      run_err("R7 master addr", 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      run_err("R9 hi addr req", 0, 1, 0, 1, 0, 0, 1, 0, 0, 1, 1, 0, 0);
      run_err("R9 hi addr no req", 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
      run_err("R9 hi data ack", 0, 1, 0, 1, 1, 0, 0, 0, 1, 0, 0, 1, 1);
      run_err("R9 hi data no ack", 0, 1, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      perr_resp_en = 0;
      run_err("R6 R8 perr off", 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
      perr_resp_en = 1; serr_en = 0;
      run_err("R7 R8 serr off", 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0);
      serr_en = 1;
      burst_err();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule